// File: doc/BRIEF.md
# Segment Address Translator with Range Check

This block turns a 16-bit logical offset, taken from an instruction, into a 24-bit physical address. It uses the segment descriptor that is currently loaded. The descriptor has three values: a base address, a lowest legal physical address and a highest legal physical address. For every request the block adds the base to the offset. It then compares the sum against both limits and returns either a translated address that memory may use or a range error.

A descriptor is written through a load port in a single cycle. Requests are single-cycle strobes with no back-pressure. One clock after a request is accepted, a registered response appears. The response carries a valid strobe, the physical address, an error flag and a memory-enable that downstream memory uses directly.

Top module: `segx_top`

## Requirements
- R1: For an in-range request, the response address equals the loaded base plus the zero-extended logical offset.
- R2: `rsp_valid` is high in exactly the cycle after each cycle where `req_valid` is high, and low otherwise.
- R3: The range check is inclusive. A sum equal to the lower limit or to the upper limit is legal, and a sum one below the lower limit or one above the upper limit raises `rsp_fault`.
- R4: When `rsp_fault` is high, `rsp_addr` is zero.
- R5: `mem_en` is high exactly when `rsp_valid` is high and `rsp_fault` is low.
- R6: A sum that carries beyond 24 bits raises `rsp_fault`, whatever the limits are.
- R7: A descriptor load affects only requests accepted in later cycles. A request in the same cycle as the load uses the previous descriptor.
- R8: After reset, `rsp_valid`, `rsp_fault`, `mem_en` and `rsp_addr` are all zero. The descriptor is base 0, lower limit 0 and upper limit all ones, so the whole space is reachable.
- R9: In a cycle that follows a cycle with no request, `rsp_addr` and `rsp_fault` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for a new descriptor |
| ld_base | input | 24 | Base address to load |
| ld_lo | input | 24 | Lowest legal physical address to load |
| ld_hi | input | 24 | Highest legal physical address to load |
| req_valid | input | 1 | Translation request strobe |
| req_offset | input | 16 | Logical offset from the instruction |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 24 | Translated physical address, zero on error or when idle |
| rsp_fault | output | 1 | Range error |
| mem_en | output | 1 | Memory access enable for a legal translation |

## Verification
The assertions check the cycle-level rules on every cycle:
- the response strobe follows the request by one cycle;
- an error always forces the address to zero;
- the memory enable matches a valid response with no error;
- every accepted address lies inside the limits that were in force when the request was taken.

Only the bench's scenarios can show that the sum itself is correct. The same holds for the exact placement of the inclusive edges, faults caused by a carry, and the ordering between a load and a request in the same cycle. The bench covers these with a full offset sweep and strided sweeps over several descriptors.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int SEGX_AW = 24;
    localparam int SEGX_OW = 16;
endpackage

// File: rtl/segx_desc_reg.sv
module segx_desc_reg #(
    parameter int AW = segx_pkg::SEGX_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_base,
    input  logic [AW-1:0] ld_lo,
    input  logic [AW-1:0] ld_hi,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] lo_q,
    output logic [AW-1:0] hi_q
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } desc_t;

    desc_t desc_d, desc_q;

    always_comb begin
        desc_d = desc_q;
        if (ld_en) begin
            desc_d.base = ld_base;
            desc_d.lo   = ld_lo;
            desc_d.hi   = ld_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q.base <= '0;
            desc_q.lo   <= '0;
            desc_q.hi   <= '1;
        end else begin
            desc_q <= desc_d;
        end
    end

    assign base_q = desc_q.base;
    assign lo_q   = desc_q.lo;
    assign hi_q   = desc_q.hi;

    // R7: the held descriptor changes only after a load strobe
    a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(base_q) && $stable(lo_q) && $stable(hi_q));
endmodule

// File: rtl/segx_xlate.sv
module segx_xlate #(
    parameter int AW = segx_pkg::SEGX_AW,
    parameter int OW = segx_pkg::SEGX_OW
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] phys,
    output logic          fault
);
    localparam int SW  = AW + 1;
    localparam int PAD = SW - OW;

    logic [SW-1:0] sum;
    logic          carry;
    logic          below;
    logic          above;

    always_comb begin
        sum   = {1'b0, base} + {{PAD{1'b0}}, offset};
        carry = sum[AW];
        below = sum[AW-1:0] < lo;
        above = sum[AW-1:0] > hi;
        fault = carry | below | above;
        phys  = fault ? '0 : sum[AW-1:0];
    end

    // R4: a faulting translation never presents a nonzero address
    a_r4_fault_zero_comb: assert final (!fault || phys == '0);
endmodule

// File: rtl/segx_rsp_reg.sv
module segx_rsp_reg #(
    parameter int AW = segx_pkg::SEGX_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] phys,
    input  logic          fault,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_fault,
    output logic          mem_en
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic          fault;
        logic          men;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.fault = fault;
            rsp_d.addr  = fault ? '0 : phys;
            rsp_d.men   = !fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_fault = rsp_q.fault;
    assign mem_en    = rsp_q.men;

    // R2: response strobe tracks the request one cycle later
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: error output forces a zero address
    a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_addr == '0);
    // R5: memory enable only for a valid, legal response
    a_r5_mem_en_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> rsp_valid && !rsp_fault);
    a_r5_mem_en_given: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> mem_en);
    // R9: idle cycles leave the response cleared
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_addr == '0 && !rsp_fault);
endmodule

// File: rtl/segx_top.sv
module segx_top #(
    parameter int AW = segx_pkg::SEGX_AW,
    parameter int OW = segx_pkg::SEGX_OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_base,
    input  logic [AW-1:0] ld_lo,
    input  logic [AW-1:0] ld_hi,
    input  logic          req_valid,
    input  logic [OW-1:0] req_offset,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_fault,
    output logic          mem_en
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] lo_q;
    logic [AW-1:0] hi_q;
    logic [AW-1:0] phys;
    logic          fault;

    segx_desc_reg #(.AW(AW)) u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_base (ld_base),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .base_q  (base_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q)
    );

    segx_xlate #(.AW(AW), .OW(OW)) u_xlate (
        .base   (base_q),
        .lo     (lo_q),
        .hi     (hi_q),
        .offset (req_offset),
        .phys   (phys),
        .fault  (fault)
    );

    segx_rsp_reg #(.AW(AW)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .phys      (phys),
        .fault     (fault),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_fault (rsp_fault),
        .mem_en    (mem_en)
    );

    // R3: every granted address lies inside the limits in force at request time
    a_r3_inside_limits: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_addr >= $past(lo_q) && rsp_addr <= $past(hi_q));
endmodule

// File: tb/segx_top_bench.sv
module segx_top_bench;
    localparam int AW = 24;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_base = '0;
    logic [AW-1:0] ld_lo = '0;
    logic [AW-1:0] ld_hi = '0;
    logic          req_valid = 1'b0;
    logic [OW-1:0] req_offset = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic          rsp_fault;
    logic          mem_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_lo = '0;
    logic [AW-1:0] m_hi = '1;

    always #10 clk = ~clk;

    segx_top u_segx_top (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_base(ld_base),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .req_valid(req_valid),
        .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .mem_en(mem_en)
    );

    task automatic check(input string tag, input logic [AW+2:0] act, input logic [AW+2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic rv, input logic [OW-1:0] ofs, input logic le,
                       input logic [AW-1:0] b, input logic [AW-1:0] l,
                       input logic [AW-1:0] h, input string tag);
        logic [AW:0]   sum;
        logic          e_fault;
        logic [AW-1:0] e_addr;
        req_valid  = rv;
        req_offset = ofs;
        ld_en      = le;
        ld_base    = b;
        ld_lo      = l;
        ld_hi      = h;
        sum     = {1'b0, m_base} + (AW+1)'(ofs);
        e_fault = rv && (sum[AW] || sum[AW-1:0] < m_lo || sum[AW-1:0] > m_hi);
        e_addr  = (rv && !e_fault) ? sum[AW-1:0] : '0;
        @(posedge clk);
        if (le) begin
            m_base = b; m_lo = l; m_hi = h;
        end
        @(negedge clk);
        check({tag, " valid R2"}, (AW+3)'(rsp_valid), (AW+3)'(rv));
        check({tag, " addr R1 R4 R9"}, (AW+3)'(rsp_addr), (AW+3)'(e_addr));
        check({tag, " fault R3 R6"}, (AW+3)'(rsp_fault), (AW+3)'(e_fault));
        check({tag, " mem_en R5"}, (AW+3)'(mem_en), (AW+3)'(rv && !e_fault));
        req_valid = 1'b0;
        ld_en     = 1'b0;
    endtask

    task automatic load(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic [AW-1:0] h);
        cyc(1'b0, '0, 1'b1, b, l, h, "load");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("reset rsp_valid R8", (AW+3)'(rsp_valid), '0);
        check("reset rsp_addr R8", (AW+3)'(rsp_addr), '0);
        check("reset rsp_fault R8", (AW+3)'(rsp_fault), '0);
        check("reset mem_en R8", (AW+3)'(mem_en), '0);
        rst_n = 1'b1;
        // R8: reset descriptor spans the whole space
        cyc(1'b1, 16'hFFFF, 1'b0, '0, '0, '0, "reset_desc R8");
        cyc(1'b1, 16'h0000, 1'b0, '0, '0, '0, "reset_desc R8");
        // R1 R3: full offset sweep, limits cut inside the reach
        load(24'h12_3400, 24'h12_3500, 24'h12_F000);
        for (int i = 0; i < 65536; i++) cyc(1'b1, OW'(i), 1'b0, '0, '0, '0, "sweep_a");
        // R3: inclusive edges exactly
        load(24'h00_1000, 24'h00_1010, 24'h00_1020);
        cyc(1'b1, 16'h000F, 1'b0, '0, '0, '0, "edge_below R3");
        cyc(1'b1, 16'h0010, 1'b0, '0, '0, '0, "edge_lo R3");
        cyc(1'b1, 16'h0020, 1'b0, '0, '0, '0, "edge_hi R3");
        cyc(1'b1, 16'h0021, 1'b0, '0, '0, '0, "edge_above R3");
        // R6: carry past the top of the space
        load(24'hFF_F000, 24'h00_0000, 24'hFF_FFFF);
        cyc(1'b1, 16'h0FFF, 1'b0, '0, '0, '0, "top_edge R6");
        cyc(1'b1, 16'h1000, 1'b0, '0, '0, '0, "carry R6");
        for (int i = 0; i < 65536; i += 251) cyc(1'b1, OW'(i), 1'b0, '0, '0, '0, "sweep_carry R6");
        // R9: idle cycles with mixed requests
        for (int i = 0; i < 40; i++) cyc(i[0], OW'(i * 997), 1'b0, '0, '0, '0, "idle_mix R9");
        // R7: load and request in the same cycle use the old descriptor
        load(24'h20_0000, 24'h20_0000, 24'h20_FFFF);
        cyc(1'b1, 16'h0100, 1'b1, 24'h40_0000, 24'h40_0080, 24'h40_00FF, "same_cycle R7");
        cyc(1'b1, 16'h0100, 1'b0, '0, '0, '0, "after_load R7");
        cyc(1'b1, 16'h0080, 1'b0, '0, '0, '0, "after_load R7");
        // strided sweeps over several descriptors
        load(24'h00_0000, 24'h00_8000, 24'h00_8000);
        for (int i = 0; i < 65536; i += 127) cyc(1'b1, OW'(i), 1'b0, '0, '0, '0, "sweep_point R3");
        load(24'hAB_CDEF, 24'hAB_0000, 24'hAB_FFFF);
        for (int i = 0; i < 65536; i += 131) cyc(1'b1, OW'(i), 1'b0, '0, '0, '0, "sweep_b R1");
        load(24'h50_0000, 24'h60_0000, 24'h40_0000);
        for (int i = 0; i < 65536; i += 509) cyc(1'b1, OW'(i), 1'b0, '0, '0, '0, "sweep_empty R3");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule